// File: doc/BRIEF.md
# Interrupt Target Register Bank

This block holds the CPU routing masks of an interrupt distributor. Every interrupt owns an 8-bit field in which bit c set means "deliver to CPU c". Four fields are packed into each 32-bit word, and the bank sits at byte offset 0x800 of the distributor's 4 KB register space. The register bus uses word addresses, so the bank starts at word address 0x200. Software reaches the bank through a simple register port with address, write data, byte strobes, and write and read enables. The routing logic downstream reads every field at once from a flat output vector.

Bits for CPUs that the chip does not implement are held at zero in every field, so software can never route to a missing core. The first 32 interrupts have fixed routing and read as zero. Any word past the implemented interrupt count, and any address outside the bank, reads zero and ignores writes. The byte strobes give byte-granular access. A read returns only the strobed lanes, and a write changes only the strobed lanes.

Top module: `irq_target_bank`

## Requirements
- R1: After reset every target field is zero, `tgt_vec` is all zero and `bus_rdata` is zero.
- R2: Word address 0x200 + k (byte offset 0x800 + 4k) holds interrupts 4k to 4k+3. Lane n, at bits 8n+7:8n, belongs to interrupt 4k+n. Field i appears on `tgt_vec[8i+7:8i]`.
- R3: Target bits for CPU numbers at or above NUM_CPUS always read as zero, and writes to them have no effect. With NUM_CPUS = 8, all eight bits of every field are writable.
- R4: A full-strobe write followed by a full-strobe read returns the written word ANDed with the valid mask, which is (1<<NUM_CPUS)-1 repeated in all four lanes. For example, 0x0103020F written with two CPUs reads back as 0x01030203.
- R5: A write changes only the lanes whose strobe bit `bus_be[n]` is set. The other fields of the word keep their values.
- R6: A read returns the masked field in each lane whose strobe bit is set, and zero in every lane whose strobe bit is clear.
- R7: The fields of interrupts 0 to 31 (words 0 to 7) always read as zero and ignore writes.
- R8: Addresses outside the bank, and bank words at index NUM_IRQS/4 or above, read as zero and ignore writes.
- R9: Read data appears on `bus_rdata` in the cycle after the one in which `bus_re` was sampled high. It holds its value while `bus_re` stays low.
- R10: A write takes effect at the clock edge where `bus_we` is high, and it shows on `tgt_vec` from the following cycle. Without a write that hits the bank, `tgt_vec` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| bus_waddr | input | 10 | Word address within the distributor space |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte strobes; bit n selects lane n for reads and writes |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 32 | Registered read data |
| tgt_vec | output | NUM_IRQS*8 | Target masks of all interrupts, field i at bits 8i+7:8i |

## Verification
The assertions assume that the chip's reset controller releases `rst_n` synchronously. They also assume that every bus input carries a known two-state value from the first edge after reset. The properties that follow a write also depend on the address and strobes being stable across the sampling edge.

The bench drives all bus inputs on the falling edge, from zero-initialised variables. It holds each address for a whole cycle and releases reset on a falling edge. This keeps every sampled input defined and away from the active edge.

// File: rtl/irq_tgt_pkg.sv
package irq_tgt_pkg;
  localparam int ADDR_W   = 10;
  localparam int IDX_W    = 8;
  localparam int LANES    = 4;
  localparam int FIELD_W  = 8;
  localparam int WORD_W   = LANES * FIELD_W;
  localparam int RO_WORDS = 32 / LANES;
  localparam logic [ADDR_W-IDX_W-1:0] BANK_SEL = 2'b10;

  function automatic logic [WORD_W-1:0] lane_mask(input int ncpu);
    logic [FIELD_W-1:0] m;
    if (ncpu >= FIELD_W) m = '1;
    else                 m = FIELD_W'((1 << ncpu) - 1);
    return {LANES{m}};
  endfunction
endpackage

// File: rtl/irq_tgt_decode.sv
module irq_tgt_decode
  import irq_tgt_pkg::*;
#(
  parameter int NUM_IRQS = 64
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  word_idx,
  output logic              hit
);
  localparam int NUM_WORDS = NUM_IRQS / LANES;

  logic in_bank;
  logic in_range;

  always_comb begin
    word_idx = addr[IDX_W-1:0];
    in_bank  = (addr[ADDR_W-1:IDX_W] == BANK_SEL);
    in_range = (int'(word_idx) < NUM_WORDS);
    hit      = in_bank && in_range;
  end
endmodule

// File: rtl/irq_tgt_store.sv
module irq_tgt_store
  import irq_tgt_pkg::*;
#(
  parameter int NUM_CPUS = 2,
  parameter int NUM_IRQS = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_word,
  input  logic [LANES-1:0]            wr_be,
  input  logic [WORD_W-1:0]           wr_data,
  output logic [NUM_IRQS*FIELD_W-1:0] fields
);
  localparam int NUM_WORDS = NUM_IRQS / LANES;
  localparam logic [WORD_W-1:0] VMASK = lane_mask(NUM_CPUS);

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    if (w < RO_WORDS) begin : g_fixed
      // fixed-routing interrupts: constant zero, no storage
      assign fields[w*WORD_W +: WORD_W] = '0;
    end else begin : g_rw
      logic              ld;
      logic [WORD_W-1:0] q;
      logic [WORD_W-1:0] d;

      assign ld = wr_en && (wr_word == IDX_W'(w));

      always_comb begin
        d = q;
        for (int l = 0; l < LANES; l++) begin
          if (wr_be[l]) begin
            d[l*FIELD_W +: FIELD_W] = wr_data[l*FIELD_W +: FIELD_W] & VMASK[l*FIELD_W +: FIELD_W];
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (ld) q <= d;
      end

      assign fields[w*WORD_W +: WORD_W] = q;
    end
  end
endmodule

// File: rtl/irq_tgt_rdport.sv
module irq_tgt_rdport
  import irq_tgt_pkg::*;
#(
  parameter int NUM_IRQS = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_en,
  input  logic                        rd_hit,
  input  logic [IDX_W-1:0]            rd_word,
  input  logic [LANES-1:0]            rd_be,
  input  logic [NUM_IRQS*FIELD_W-1:0] fields,
  output logic [WORD_W-1:0]           rdata
);
  localparam int NUM_WORDS = NUM_IRQS / LANES;

  logic [WORD_W-1:0] sel;
  logic [WORD_W-1:0] be_mask;
  logic [WORD_W-1:0] rdata_d;

  always_comb begin
    sel = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (rd_word == IDX_W'(w)) sel = fields[w*WORD_W +: WORD_W];
    end
    for (int l = 0; l < LANES; l++) begin
      be_mask[l*FIELD_W +: FIELD_W] = {FIELD_W{rd_be[l]}};
    end
    rdata_d = rd_hit ? (sel & be_mask) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rdata_d;
  end
endmodule

// File: rtl/irq_target_bank.sv
module irq_target_bank
  import irq_tgt_pkg::*;
#(
  parameter int NUM_CPUS = 2,
  parameter int NUM_IRQS = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_waddr,
  input  logic [WORD_W-1:0]           bus_wdata,
  input  logic [LANES-1:0]            bus_be,
  input  logic                        bus_we,
  input  logic                        bus_re,
  output logic [WORD_W-1:0]           bus_rdata,
  output logic [NUM_IRQS*FIELD_W-1:0] tgt_vec
);
  logic [IDX_W-1:0] word_idx;
  logic             hit;
  logic             wr_en;

  irq_tgt_decode #(.NUM_IRQS(NUM_IRQS)) u_dec (
    .addr     (bus_waddr),
    .word_idx (word_idx),
    .hit      (hit)
  );

  assign wr_en = bus_we && hit;

  irq_tgt_store #(.NUM_CPUS(NUM_CPUS), .NUM_IRQS(NUM_IRQS)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_word (word_idx),
    .wr_be   (bus_be),
    .wr_data (bus_wdata),
    .fields  (tgt_vec)
  );

  irq_tgt_rdport #(.NUM_IRQS(NUM_IRQS)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (bus_re),
    .rd_hit  (hit),
    .rd_word (word_idx),
    .rd_be   (bus_be),
    .fields  (tgt_vec),
    .rdata   (bus_rdata)
  );
endmodule

// File: rtl/irq_target_bank_chk.sv
module irq_target_bank_chk
  import irq_tgt_pkg::*;
#(
  parameter int NUM_CPUS = 2,
  parameter int NUM_IRQS = 64
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [ADDR_W-1:0]           bus_waddr,
  input logic [WORD_W-1:0]           bus_wdata,
  input logic [LANES-1:0]            bus_be,
  input logic                        bus_we,
  input logic                        bus_re,
  input logic [WORD_W-1:0]           bus_rdata,
  input logic [NUM_IRQS*FIELD_W-1:0] tgt_vec
);
  localparam int NUM_WORDS = NUM_IRQS / LANES;
  localparam logic [WORD_W-1:0] VMASK = lane_mask(NUM_CPUS);

  logic             bank_ok;
  logic             writable;
  logic [IDX_W-1:0] idx_q;
  logic [WORD_W-1:0] word_at_q;

  always_comb begin
    bank_ok  = (bus_waddr[ADDR_W-1:IDX_W] == 2'b10) && (int'(bus_waddr[IDX_W-1:0]) < NUM_WORDS);
    writable = bank_ok && (int'(bus_waddr[IDX_W-1:0]) >= RO_WORDS);
    word_at_q = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (idx_q == IDX_W'(w)) word_at_q = tgt_vec[w*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= bus_waddr[IDX_W-1:0];
  end

  a_r3_unimpl_cpu_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_vec & ~{NUM_WORDS{VMASK}}) == '0);

  a_r7_fixed_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_vec[RO_WORDS*WORD_W-1:0] == '0);

  a_r8_outside_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && !bank_ok) |=> (bus_rdata == '0));

  a_r8_outside_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bank_ok) |=> $stable(tgt_vec));

  a_r6_no_lane_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_be == '0) |=> (bus_rdata == '0));

  a_r9_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));

  a_r10_no_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(tgt_vec));

  a_r4_word_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && writable && bus_be == '1) |=> (word_at_q == ($past(bus_wdata) & VMASK)));
endmodule

bind irq_target_bank irq_target_bank_chk #(.NUM_CPUS(NUM_CPUS), .NUM_IRQS(NUM_IRQS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_waddr (bus_waddr),
  .bus_wdata (bus_wdata),
  .bus_be    (bus_be),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .bus_rdata (bus_rdata),
  .tgt_vec   (tgt_vec)
);

// File: tb/irq_target_bank_tb.sv
module irq_target_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IRQS  = 64;
  localparam int NW    = IRQS / 4;
  localparam logic [31:0] MASK_A = 32'h0303_0303;
  localparam logic [31:0] MASK_B = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0]  waddr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  be = '0;
  logic we = 1'b0;
  logic re = 1'b0;
  logic [31:0] rdata_a, rdata_b;
  logic [IRQS*8-1:0] vec_a, vec_b;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [31:0] shadow [NW];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_target_bank #(.NUM_CPUS(2), .NUM_IRQS(IRQS)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_waddr(waddr), .bus_wdata(wdata), .bus_be(be),
    .bus_we(we), .bus_re(re), .bus_rdata(rdata_a), .tgt_vec(vec_a));

  irq_target_bank #(.NUM_CPUS(8), .NUM_IRQS(IRQS)) u_dut_full (
    .clk(clk), .rst_n(rst_n), .bus_waddr(waddr), .bus_wdata(wdata), .bus_be(be),
    .bus_we(we), .bus_re(re), .bus_rdata(rdata_b), .tgt_vec(vec_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lanes(input logic [3:0] b);
    logic [31:0] m;
    for (int l = 0; l < 4; l++) m[l*8 +: 8] = {8{b[l]}};
    return m;
  endfunction

  function automatic bit bank_rw(input logic [9:0] a);
    return (a[9:8] == 2'b10) && (int'(a[7:0]) < NW) && (int'(a[7:0]) >= 8);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [9:0] a, input logic [3:0] b, input logic [31:0] m);
    if (!bank_rw(a)) return 32'h0;
    return shadow[a[3:0]] & m & lanes(b);
  endfunction

  task automatic do_write(input logic [9:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    waddr = a; wdata = d; be = b; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    if (bank_rw(a))
      for (int l = 0; l < 4; l++)
        if (b[l]) shadow[a[3:0]][l*8 +: 8] = d[l*8 +: 8];
  endtask

  task automatic do_read(input logic [9:0] a, input logic [3:0] b,
                         output logic [31:0] ra, output logic [31:0] rb);
    @(negedge clk);
    waddr = a; be = b; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    ra = rdata_a; rb = rdata_b;
  endtask

  task automatic check_vec(input string req);
    for (int w = 0; w < NW; w++) begin
      logic [31:0] e;
      e = (w >= 8) ? shadow[w] : 32'h0;
      chk(req, vec_a[w*32 +: 32], e & MASK_A);
      chk(req, vec_b[w*32 +: 32], e & MASK_B);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL R9 watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [31:0] ra, rb, old_a, old_b;
    for (int w = 0; w < NW; w++) shadow[w] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 rdata", rdata_a, 32'h0);
    chk("R1 rdata", rdata_b, 32'h0);
    check_vec("R1 vec");

    // R2 R4 R3 R7 R8: full-word sweep, including past the interrupt count
    for (int w = 0; w < 20; w++)
      do_write({2'b10, 8'(w)}, 32'hA5C3_0F96 ^ (32'(w) * 32'h0111_0101), 4'hF);
    for (int w = 0; w < 20; w++) begin
      do_read({2'b10, 8'(w)}, 4'hF, ra, rb);
      chk("R2 R4 R7 R8 word read cpu2", ra, exp_rd({2'b10, 8'(w)}, 4'hF, MASK_A));
      chk("R3 word read cpu8", rb, exp_rd({2'b10, 8'(w)}, 4'hF, MASK_B));
    end
    check_vec("R2 vec layout");

    // R7: fixed low words stay zero after writes
    do_write(10'h203, 32'hFFFF_FFFF, 4'hF);
    do_read(10'h203, 4'hF, ra, rb);
    chk("R7 fixed word", ra, 32'h0);
    chk("R7 fixed word", rb, 32'h0);

    // R8: outside bank, mirror of a live word
    do_write(10'h10A, 32'hFFFF_FFFF, 4'hF);
    do_write(10'h30A, 32'hFFFF_FFFF, 4'hF);
    check_vec("R8 outside write");
    do_read(10'h10A, 4'hF, ra, rb);
    chk("R8 outside read", ra, 32'h0);
    chk("R8 outside read", rb, 32'h0);

    // R4: worked example at offset 0x820
    do_write(10'h208, 32'h0103_020F, 4'hF);
    do_read(10'h208, 4'hF, ra, rb);
    chk("R4 example cpu2", ra, 32'h0103_0203);
    chk("R3 example cpu8", rb, 32'h0103_020F);

    // R6: single-lane reads
    for (int l = 0; l < 4; l++) begin
      do_read(10'h208, 4'(1 << l), ra, rb);
      chk("R6 lane read", ra, exp_rd(10'h208, 4'(1 << l), MASK_A));
      chk("R6 lane read", rb, exp_rd(10'h208, 4'(1 << l), MASK_B));
    end

    // R5: every strobe pattern on one word
    for (int b = 0; b < 16; b++) begin
      do_write(10'h20A, 32'h8844_2211 * 32'(b + 1), 4'(b));
      chk("R5 strobe write", vec_a[10*32 +: 32], shadow[10] & MASK_A);
      chk("R5 strobe write", vec_b[10*32 +: 32], shadow[10] & MASK_B);
    end
    do_write(10'h20A, 32'h0000_0400, 4'b0100);
    do_write(10'h20A, 32'h0004_0000, 4'b0100);
    do_read(10'h20A, 4'hF, ra, rb);
    chk("R5 byte write", ra, shadow[10] & MASK_A);
    chk("R5 byte write", rb, shadow[10] & MASK_B);

    // R10: nothing before the edge, new value after it
    @(negedge clk);
    old_a = vec_a[12*32 +: 32];
    waddr = 10'h20C; wdata = 32'h0102_0408; be = 4'hF; we = 1'b1;
    #1;
    chk("R10 before edge", vec_a[12*32 +: 32], old_a);
    @(negedge clk);
    we = 1'b0;
    shadow[12] = 32'h0102_0408;
    chk("R10 after edge", vec_a[12*32 +: 32], 32'h0102_0000);
    chk("R10 after edge", vec_b[12*32 +: 32], 32'h0102_0408);

    // R9: timing and hold of read data
    do_read(10'h208, 4'hF, ra, rb);
    old_a = rdata_a; old_b = rdata_b;
    @(negedge clk);
    waddr = 10'h209; be = 4'hF;
    repeat (3) begin
      @(negedge clk);
      chk("R9 hold", rdata_a, old_a);
      chk("R9 hold", rdata_b, old_b);
    end
    @(negedge clk);
    re = 1'b1;
    #1;
    chk("R9 not before edge", rdata_a, old_a);
    @(negedge clk);
    re = 1'b0;
    chk("R9 one cycle", rdata_a, shadow[9] & MASK_A);

    check_vec("R3 R10 final vec");
    finish_run();
  end
endmodule